// File: doc/BRIEF.md
# I2C Byte Shifter with Address Match

This block is the byte-level datapath of an I2C port. A single 8-bit register serves both directions. In receive, each sampled SDA bit enters at bit 0 and the contents move one place left. In transmit, the most significant bit is presented first on the serial output and the register moves left after every bit. Both bus lines pass through a two-sample noise filter. The shift clock is the filtered SCL delayed by one system clock, and data is captured on its rising edge. A 3-bit counter tracks the bits. After the eighth bit the block raises a one-cycle byte-complete pulse. On the first byte after a counter reset, it compares the upper seven received bits against a programmable own-address value.

The CPU side works through strobes. One strobe loads the shift register, and it is honoured only while the enable input is high. A second strobe loads the own address. The shift register can be read at all times. A load made while enabled and in master mode clears the bit counter and starts a local SCL generator. That generator runs eight clock periods and then releases the line high. Start and stop detection, arbitration, acknowledge handling and the pad drivers sit outside this block.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, rd_data is 0x00, sda_out and scl_out are 1, byte_done and addr_match are 0.
- R2: An SCL or SDA level is accepted only once two consecutive system-clock samples agree. A high or low pulse lasting one clock on either line causes no shift and does not change the captured bit.
- R3: On each rising edge of the shift clock (filtered SCL delayed by one clock) while enabled, the filtered SDA bit enters bit 0 and the register moves left. After eight bits, rd_data equals the byte sent MSB first.
- R4: A register load sets sda_out to bit 7 of the written value. After each filtered SCL falling edge, sda_out takes the current bit 7 of the register. sda_out changes at no other time, so a byte loaded for transmit appears MSB first at the SCL rising edges.
- R5: A shift-register load strobe while if_en is 0 has no effect. The register, sda_out and scl_out keep their values.
- R6: rd_data always shows the shift register, whatever the value of if_en.
- R7: A load with if_en=1 and master_mode=1 clears the bit counter and starts the SCL generator. The generator drives scl_out low for HALF_CYC clocks and then high for HALF_CYC clocks, eight times, and then holds scl_out at 1.
- R8: byte_done is a pulse of exactly one clock, raised once per eight shifted bits.
- R9: addr_match is cleared when the bit counter resets (if_en low, or a master-mode load). At the end of the first byte after such a reset, it is set exactly when bits 7..1 of that byte equal the own address. The flag then holds through later bytes. The own address is loaded from wdata[6:0] by addr_wr.
- R10: While if_en is 0, the bit counter stays at 0 and SCL activity neither shifts the register nor raises byte_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sh_wr | input | 1 | Shift-register load strobe |
| addr_wr | input | 1 | Own-address load strobe |
| wdata | input | 8 | Write data for both strobes |
| if_en | input | 1 | Interface enable |
| master_mode | input | 1 | Master mode select |
| rd_data | output | 8 | Shift-register contents |
| sda_out | output | 1 | Serial data bit to drive |
| scl_out | output | 1 | SCL level requested in master mode (1 = released) |
| byte_done | output | 1 | One-clock pulse after the eighth bit |
| addr_match | output | 1 | First received byte matched the own address |

## Verification
Every byte value is received twice in slave mode, once as an address byte and once as a follow-on byte. A design that compared the wrong bit slice, or that re-evaluated the match on later bytes, would raise or drop addr_match on some values. Every byte value is also sent in master mode with SDA looped back. A generator that miscounted periods, or an output that changed while SCL was high, would show up as the wrong number of SCL rises or a corrupted captured byte. One-clock glitches are injected on SCL during its low phase and on SDA next to the sampling edge. A missing filter would then add a shift or capture an inverted bit. Loads and clock activity are also applied while the interface is disabled, and they must leave the register and the outputs untouched.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sh_wr,
  input  logic       addr_wr,
  input  logic [7:0] wdata,
  input  logic       if_en,
  input  logic       master_mode,
  output logic [7:0] rd_data,
  output logic       sda_out,
  output logic       scl_out,
  output logic       byte_done,
  output logic       addr_match
);

  localparam int PW = $clog2(HALF_CYC + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

  logic          scl_s, scl_f, sda_s, sda_f, sclk_d;
  logic [7:0]    shreg;
  logic [6:0]    own_adr;
  logic [2:0]    bit_cnt;
  logic          first_q, sda_q;
  logic          scl_run;
  logic [PW-1:0] ph;
  logic [2:0]    gen_cnt;

  wire load       = sh_wr & if_en;
  wire restart    = load & master_mode;
  wire cnt_clr    = ~if_en | restart;
  wire shift_rise = if_en & scl_f & ~sclk_d;
  wire shift_fall = if_en & ~scl_f & sclk_d;
  wire last_bit   = shift_rise & (bit_cnt == 3'd7);

  assign rd_data = shreg;
  assign sda_out = sda_q;

  // two-sample noise filter and shift-clock delay
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 1'b1; scl_f <= 1'b1;
      sda_s <= 1'b1; sda_f <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      if (scl_in == scl_s) scl_f <= scl_in;
      if (sda_in == sda_s) sda_f <= sda_in;
      sclk_d <= scl_f;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      sda_q <= 1'b1;
    end else begin
      if (load)            shreg <= wdata;
      else if (shift_rise) shreg <= {shreg[6:0], sda_f};
      if (load)            sda_q <= wdata[7];
      else if (shift_fall) sda_q <= shreg[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          own_adr <= '0;
    else if (addr_wr)    own_adr <= wdata[6:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt    <= '0;
      first_q    <= 1'b1;
      addr_match <= 1'b0;
      byte_done  <= 1'b0;
    end else begin
      byte_done <= last_bit & ~cnt_clr;
      if (cnt_clr) begin
        bit_cnt    <= '0;
        first_q    <= 1'b1;
        addr_match <= 1'b0;
      end else if (shift_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        if (last_bit) begin
          first_q <= 1'b0;
          if (first_q) addr_match <= (shreg[6:0] == own_adr);
        end
      end
    end

  // master SCL generator: low half, high half, eight periods
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_run <= 1'b0;
      scl_out <= 1'b1;
      ph      <= '0;
      gen_cnt <= '0;
    end else if (restart) begin
      scl_run <= 1'b1;
      scl_out <= 1'b0;
      ph      <= '0;
      gen_cnt <= '0;
    end else if (!if_en) begin
      scl_run <= 1'b0;
      scl_out <= 1'b1;
    end else if (scl_run) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        if (!scl_out)             scl_out <= 1'b1;
        else if (gen_cnt == 3'd7) scl_run <= 1'b0;
        else begin
          scl_out <= 1'b0;
          gen_cnt <= gen_cnt + 3'd1;
        end
      end else begin
        ph <= ph + PW'(1);
      end
    end

  initial assert (HALF_CYC >= 3) else $error("HALF_CYC must cover the filter delay");

  // R8
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R5
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> $stable(rd_data));

  // R9
  match_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> byte_done);

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_out) |-> $past(!scl_f || load));

  // R7
  scl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_run && !restart) |=> scl_out);

  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (bit_cnt == 3'd0));

endmodule

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
  localparam int CLK_NS = 10;
  localparam int HALF = 4;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1, lb = 1'b0;
  logic sh_wr = 1'b0, addr_wr = 1'b0, if_en = 1'b0, master_mode = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic sda_out, scl_out, byte_done, addr_match;
  logic scl_in, sda_in;

  assign scl_in = lb ? scl_out : scl_drv;
  assign sda_in = lb ? sda_out : sda_drv;

  i2c_byte_shifter #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sh_wr(sh_wr), .addr_wr(addr_wr), .wdata(wdata), .if_en(if_en),
    .master_mode(master_mode), .rd_data(rd_data), .sda_out(sda_out),
    .scl_out(scl_out), .byte_done(byte_done), .addr_match(addr_match));

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, fails = 0, dones = 0, rises = 0;
  logic [7:0] cap = '0;
  logic scl_prev = 1'b1;
  bit finished = 0;

  always @(negedge clk) begin
    if (byte_done) dones++;
    if (scl_out && !scl_prev) begin
      rises++;
      cap = {cap[6:0], sda_out};
    end
    scl_prev = scl_out;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit g);
    sda_drv = b; scl_drv = 1'b0; tick(1);
    if (g) scl_drv = 1'b1;
    tick(1); scl_drv = 1'b0; tick(2);
    scl_drv = 1'b1; tick(1);
    if (g) sda_drv = ~b;
    tick(1); sda_drv = b; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit g);
    for (int i = 7; i >= 0; i--) send_bit(v[i], g);
    tick(4);
  endtask

  task automatic reenable();
    if_en = 1'b0; tick(2); if_en = 1'b1; tick(2);
  endtask

  task automatic write_sh(input logic [7:0] v);
    wdata = v; sh_wr = 1'b1; tick(1); sh_wr = 1'b0;
  endtask

  initial begin
    int d0;
    logic [7:0] keep;
    logic ks;
    tick(3); rst_n = 1'b1; tick(1);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(sda_out && scl_out, "R1 lines", {sda_out, scl_out}, 3);
    chk(!byte_done && !addr_match, "R1 flags", {byte_done, addr_match}, 0);

    wdata = {1'b0, OWN}; addr_wr = 1'b1; tick(1); addr_wr = 1'b0;

    for (int b = 0; b < 256; b++) begin
      reenable();
      d0 = dones;
      send_byte(8'(b), 1'b0);
      chk(rd_data == 8'(b), "R3 receive", rd_data, b);
      chk(dones == d0 + 1, "R8 pulse", dones - d0, 1);
      chk(addr_match == (7'(b >> 1) == OWN), "R9 first byte", addr_match, 7'(b >> 1) == OWN);
      send_byte(~8'(b), 1'b0);
      chk(rd_data == ~8'(b), "R3 second byte", rd_data, ~8'(b));
      chk(addr_match == (7'(b >> 1) == OWN), "R9 held", addr_match, 7'(b >> 1) == OWN);
    end

    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      v = 8'h35 + 8'(k * 37);
      reenable();
      d0 = dones;
      send_byte(v, 1'b1);
      chk(rd_data == v, "R2 glitch", rd_data, v);
      chk(dones == d0 + 1, "R2 glitch count", dones - d0, 1);
    end

    keep = rd_data; ks = sda_out;
    if_en = 1'b0; tick(2);
    chk(rd_data == keep, "R6 read disabled", rd_data, keep);
    d0 = dones;
    send_byte(8'hC3, 1'b0);
    chk(rd_data == keep, "R10 no shift", rd_data, keep);
    chk(dones == d0, "R10 no done", dones - d0, 0);
    master_mode = 1'b1;
    write_sh(~keep);
    tick(20);
    chk(rd_data == keep, "R5 gated load", rd_data, keep);
    chk(scl_out == 1'b1, "R5 no scl", scl_out, 1);
    chk(sda_out == ks, "R5 sda kept", sda_out, ks);

    if_en = 1'b1; lb = 1'b1; tick(2);
    for (int w = 0; w < 256; w++) begin
      int r0;
      d0 = dones; r0 = rises;
      write_sh(8'(w));
      chk(scl_out == 1'b0, "R7 scl start", scl_out, 0);
      chk(sda_out == w[7], "R4 msb on load", sda_out, w[7]);
      tick(16 * HALF + 12);
      chk(rises - r0 == 8, "R7 periods", rises - r0, 8);
      chk(cap == 8'(w), "R4 msb first", cap, w);
      chk(rd_data == 8'(w), "R3 loopback", rd_data, w);
      chk(dones == d0 + 1, "R8 master pulse", dones - d0, 1);
      chk(scl_out == 1'b1, "R7 released", scl_out, 1);
      chk(addr_match == (7'(w >> 1) == OWN), "R9 master reset", addr_match, 7'(w >> 1) == OWN);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule